// File: doc/BRIEF.md
# SCSI Initiator Phase Monitor

This block sits on the initiator side of a SCSI bus and watches its control lines. Every incoming line first passes through a synchronizer. The block then compares the live information-transfer phase with an expected phase that software has programmed. While the two differ, the block raises a stall to the byte-transfer logic so that no data moves. Data stays frozen until software programs a phase that agrees with the bus, or until the bus returns to the expected phase.

The block also turns bus events into status flags. These events are REQ edges, bus reset, bus-free, inbound parity errors, phase changes and selection timeouts. Each flag follows its own clearing rule. Each flag has an enable bit at the same position, and the enabled flags combine into one registered interrupt. Software reaches the block through a byte-wide register port with an address, a write strobe and a read strobe. Status and its write-one-to-clear register share one address.

Top module: `scsi_phase_mon`

## Requirements
- R1: The phase code is the 3-bit value {C/D, I/O, MSG}. The six phases use these codes: DATA OUT 000, DATA IN 010, COMMAND 100, STATUS 110, MESSAGE OUT 101, MESSAGE IN 111. The expected phase is held in bits 7:5 of register 0, with bit 7 = C/D, bit 6 = I/O and bit 5 = MSG.
- R2: The register map has three entries. Address 0 holds the expected phase; it reads back as {phase, 00000}. Address 1 returns status when read and clears flags when written. Address 2 holds the interrupt enables. A read of address 3 returns 0. rdata_o loads on the clock edge where rd_i is high and holds its value otherwise.
- R3: stall_o is high whenever the synchronized phase differs from the expected phase. It falls in the cycle after software writes a matching expected phase.
- R4: Status bit 4 is a live mismatch indication and is not stored. Writing 1 to bit 4 of address 1 has no effect on it.
- R5: Status bit 1 sets when the synchronized phase changes value. It stays set until software writes 1 to bit 1 of address 1.
- R6: Status bit 0 sets on a rising edge of REQ. It clears when software writes 1 to bit 0, or while the synchronized ACK is high. A set in the same cycle wins over a clear.
- R7: Four status bits are sticky and clear only by writing 1 to their own position at address 1: bit 7 (a seltmo_i pulse), bit 5 (a rising edge of the bus reset line), bit 3 (bus free) and bit 2 (parity error). Holding the bus reset line high does not set bit 5 again after a clear.
- R8: Bit 3 sets once BSY and SEL have both been low for BUS_FREE_CYC consecutive synchronized samples, default 2. It sets only after the bus has been busy, and only once in each idle period.
- R9: Bit 2 sets on a REQ rising edge during DATA IN when the data byte plus its parity bit has an even number of ones. No such edge in any other phase sets it.
- R10: irq_o is registered. It goes high one cycle after any status bit and the enable bit at the same position are both 1, and goes low one cycle after no such pair remains. Status bit 6 always reads 0.
- R11: A bus line change driven before clock edge k shows on stall_o after edge k+1. The status flag for that change sets at edge k+2.
- R12: After reset the expected phase, all status flags, all enables, rdata_o, irq_o and stall_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cd_i | input | 1 | Bus C/D line |
| io_i | input | 1 | Bus I/O line |
| msg_i | input | 1 | Bus MSG line |
| req_i | input | 1 | Bus REQ line |
| ack_i | input | 1 | Bus ACK line |
| bsy_i | input | 1 | Bus BSY line |
| sel_i | input | 1 | Bus SEL line |
| brst_i | input | 1 | Bus reset line |
| db_i | input | 8 | Bus data byte |
| dbp_i | input | 1 | Bus data parity bit |
| seltmo_i | input | 1 | Selection timeout pulse from the selection logic |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| stall_o | output | 1 | Holds the data-transfer path while the phase mismatches |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound assertions are checked on every cycle. They cover the stall release after a matching phase write, the interrupt tracking the masked status, ACK clearing the REQ flag, the selection-timeout flag staying set until a clear, and any phase change setting the sticky flag. Only the bench's scenarios can show the rest: odd against even parity across phases, the bus-free condition firing once per idle period, bus reset being edge-triggered while the line is held, the exact synchronizer latency and the readback encodings. A behavioural model in the bench follows every cycle to catch stray flag changes.

// File: rtl/scsi_mon_pkg.sv
`timescale 1ns/1ps
package scsi_mon_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    PH_DOUT = 3'b000,
    PH_DIN  = 3'b010,
    PH_CMD  = 3'b100,
    PH_STAT = 3'b110,
    PH_MOUT = 3'b101,
    PH_MIN  = 3'b111
  } phase_e;

  localparam int unsigned B_SELTO = 7;
  localparam int unsigned B_RSTIN = 5;
  localparam int unsigned B_PHMIS = 4;
  localparam int unsigned B_BFREE = 3;
  localparam int unsigned B_PERR  = 2;
  localparam int unsigned B_PHCHG = 1;
  localparam int unsigned B_REQ   = 0;
  localparam logic [DW-1:0] STICKY_MASK = 8'b1010_1111;

  localparam int unsigned A_EXP  = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_EN   = 2;

  typedef struct packed {
    logic [2:0]    ph;   // {C/D, I/O, MSG}
    logic          req;
    logic          ack;
    logic          bsy;
    logic          sel;
    logic          brst;
    logic [DW-1:0] db;
    logic          dbp;
  } bus_t;

  typedef struct packed {
    logic seltmo;
    logic rstin;
    logic bfree;
    logic perr;
    logic phchg;
    logic req_set;
    logic req_clr;
  } evt_t;
endpackage

// File: rtl/scsi_sync.sv
`timescale 1ns/1ps
module scsi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int SW = W * STAGES;

  logic [SW-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[SW-W-1:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[SW-1 -: W];
endmodule

// File: rtl/scsi_event_det.sv
`timescale 1ns/1ps
module scsi_event_det
  import scsi_mon_pkg::*;
#(
  parameter int BUS_FREE_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bus_t       cur_i,
  input  logic       seltmo_i,
  output evt_t       evt_o,
  output logic [2:0] prev_ph_o,
  output logic       req_rise_o
);
  localparam int CW = $clog2(BUS_FREE_CYC + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(BUS_FREE_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(BUS_FREE_CYC - 1);

  logic [2:0]    prev_ph_q;
  logic          prev_req_q, prev_rst_q;
  logic [CW-1:0] idle_cnt_q;
  logic          idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ph_q  <= '0;
      prev_req_q <= 1'b0;
      prev_rst_q <= 1'b0;
    end else begin
      prev_ph_q  <= cur_i.ph;
      prev_req_q <= cur_i.req;
      prev_rst_q <= cur_i.brst;
    end
  end

  assign idle = !cur_i.bsy && !cur_i.sel;

  // Reset to saturated: no bus-free event until the bus has been busy.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    idle_cnt_q <= CNT_SAT;
    else if (!idle)                 idle_cnt_q <= '0;
    else if (idle_cnt_q != CNT_SAT) idle_cnt_q <= idle_cnt_q + 1'b1;
  end

  assign req_rise_o = cur_i.req && !prev_req_q;
  assign prev_ph_o  = prev_ph_q;

  always_comb begin
    evt_o         = '0;
    evt_o.seltmo  = seltmo_i;
    evt_o.rstin   = cur_i.brst && !prev_rst_q;
    evt_o.bfree   = idle && (idle_cnt_q == CNT_LAST);
    evt_o.perr    = req_rise_o && (cur_i.ph == PH_DIN) && !(^{cur_i.db, cur_i.dbp});
    evt_o.phchg   = cur_i.ph != prev_ph_q;
    evt_o.req_set = req_rise_o;
    evt_o.req_clr = cur_i.ack;
  end
endmodule

// File: rtl/scsi_status_regs.sv
`timescale 1ns/1ps
module scsi_status_regs
  import scsi_mon_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  evt_t              evt_i,
  input  logic [2:0]        live_ph_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     status_o,
  output logic [DW-1:0]     en_o,
  output logic              mismatch_o,
  output logic              irq_o
);
  logic [2:0]    exp_q;
  logic [DW-1:0] en_q;
  logic          wr_exp, wr_clr, wr_en;

  assign wr_exp = wr_i && (addr_i == ADDR_W'(A_EXP));
  assign wr_clr = wr_i && (addr_i == ADDR_W'(A_STAT));
  assign wr_en  = wr_i && (addr_i == ADDR_W'(A_EN));

  assign mismatch_o = live_ph_i != exp_q;

  function automatic logic evt_bit(evt_t e, int unsigned b);
    case (b)
      B_SELTO: return e.seltmo;
      B_RSTIN: return e.rstin;
      B_BFREE: return e.bfree;
      B_PERR:  return e.perr;
      B_PHCHG: return e.phchg;
      B_REQ:   return e.req_set;
      default: return 1'b0;
    endcase
  endfunction

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (STICKY_MASK[b]) begin : g_sticky
      logic flag_q, set_b, clr_b;
      assign set_b = evt_bit(evt_i, b);
      if (b == B_REQ) begin : g_reqclr
        assign clr_b = (wr_clr && wdata_i[b]) || evt_i.req_clr;
      end else begin : g_swclr
        assign clr_b = wr_clr && wdata_i[b];
      end
      // A set wins over a clear in the same cycle.
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= set_b || (flag_q && !clr_b);
      assign status_o[b] = flag_q;
    end else if (b == B_PHMIS) begin : g_live
      assign status_o[b] = mismatch_o;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q   <= PH_DOUT;
      en_q    <= '0;
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (wr_exp) exp_q <= wdata_i[7:5];
      if (wr_en)  en_q  <= wdata_i;
      irq_o <= |(status_o & en_q);
      if (rd_i) begin
        case (addr_i)
          ADDR_W'(A_EXP):  rdata_o <= {exp_q, 5'b0};
          ADDR_W'(A_STAT): rdata_o <= status_o;
          ADDR_W'(A_EN):   rdata_o <= en_q;
          default:         rdata_o <= '0;
        endcase
      end
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/scsi_phase_mon.sv
`timescale 1ns/1ps
module scsi_phase_mon
  import scsi_mon_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int BUS_FREE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cd_i,
  input  logic              io_i,
  input  logic              msg_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              bsy_i,
  input  logic              sel_i,
  input  logic              brst_i,
  input  logic [7:0]        db_i,
  input  logic              dbp_i,
  input  logic              seltmo_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              stall_o,
  output logic              irq_o
);
  localparam int BW = $bits(bus_t);

  bus_t          raw, cur;
  logic [BW-1:0] cur_v;
  evt_t          evt;
  logic [2:0]    live_ph, prev_ph;
  logic          req_rise;
  logic [DW-1:0] status, en;

  always_comb begin
    raw      = '0;
    raw.ph   = {cd_i, io_i, msg_i};
    raw.req  = req_i;
    raw.ack  = ack_i;
    raw.bsy  = bsy_i;
    raw.sel  = sel_i;
    raw.brst = brst_i;
    raw.db   = db_i;
    raw.dbp  = dbp_i;
  end

  scsi_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (cur_v)
  );

  assign cur     = bus_t'(cur_v);
  assign live_ph = cur.ph;

  scsi_event_det #(.BUS_FREE_CYC(BUS_FREE_CYC)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (cur),
    .seltmo_i   (seltmo_i),
    .evt_o      (evt),
    .prev_ph_o  (prev_ph),
    .req_rise_o (req_rise)
  );

  scsi_status_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .live_ph_i  (live_ph),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .status_o   (status),
    .en_o       (en),
    .mismatch_o (stall_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/scsi_phase_mon_chk.sv
`timescale 1ns/1ps
module scsi_phase_mon_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              stall_o,
  input logic              irq_o,
  input logic [2:0]        live_ph,
  input logic [2:0]        prev_ph,
  input logic              ack_s,
  input logic              req_rise,
  input logic [7:0]        status,
  input logic [7:0]        en
);
  assert_stall_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(0) && wdata_i[7:5] == live_ph)
      |=> (!stall_o || live_ph != $past(live_ph)));

  assert_phchg_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_ph != prev_ph) |=> status[1]);

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_s && !req_rise) |=> !status[0]);

  assert_selto_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[7] && !(wr_i && addr_i == ADDR_W'(1) && wdata_i[7])) |=> status[7]);

  assert_irq_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & en) == 8'h00) |=> !irq_o);

  assert_irq_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & en) != 8'h00) |=> irq_o);
endmodule

bind scsi_phase_mon scsi_phase_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .stall_o  (stall_o),
  .irq_o    (irq_o),
  .live_ph  (live_ph),
  .prev_ph  (prev_ph),
  .ack_s    (cur.ack),
  .req_rise (req_rise),
  .status   (status),
  .en       (en)
);

// File: tb/tb_scsi_phase_mon.sv
`timescale 1ns/1ps
module tb_scsi_phase_mon;
  localparam int FREE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cd = 0, io = 0, msg = 0, req = 0, ack = 0, bsy = 0, sel = 0, brst = 0, dbp = 0, seltmo = 0;
  logic wr = 0, rd = 0;
  logic [7:0] db = 0, wdata = 0;
  logic [1:0] addr = 0;
  logic [7:0] rdata;
  logic stall, irq;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  scsi_phase_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .cd_i(cd), .io_i(io), .msg_i(msg), .req_i(req),
    .ack_i(ack), .bsy_i(bsy), .sel_i(sel), .brst_i(brst), .db_i(db), .dbp_i(dbp),
    .seltmo_i(seltmo), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .stall_o(stall), .irq_o(irq)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int ph; int req; int ack; int bsy; int sel; int brst; int db; int dbp; } smp_t;
  smp_t hist[$];
  int m_exp, m_en, m_rd, m_irq, m_stall, m_st, m_idle;
  bit m_armed;

  function automatic smp_t zero_smp();
    smp_t z;
    z = '{0, 0, 0, 0, 0, 0, 0, 0};
    return z;
  endfunction

  always @(posedge clk) begin
    smp_t s, c, p;
    int st_full, set, clr;
    if (!rst_n) begin
      hist = {zero_smp(), zero_smp(), zero_smp(), zero_smp()};
      m_exp = 0; m_en = 0; m_rd = 0; m_irq = 0; m_stall = 0; m_st = 0;
      m_idle = 0; m_armed = 0;
    end else begin
      s = '{int'({cd, io, msg}), int'(req), int'(ack), int'(bsy), int'(sel), int'(brst),
            int'(db), int'(dbp)};
      hist.push_front(s);
      void'(hist.pop_back());
      c = hist[2];
      p = hist[3];
      st_full = m_st | ((c.ph != m_exp) ? 32'h10 : 0);
      m_irq = ((st_full & m_en) != 0) ? 1 : 0;
      if (rd) m_rd = (addr == 0) ? (m_exp << 5) : (addr == 1) ? st_full : (addr == 2) ? m_en : 0;
      set = 0;
      if (seltmo) set |= 8'h80;
      if (c.brst && !p.brst) set |= 8'h20;
      if (c.ph != p.ph) set |= 8'h02;
      if (c.req && !p.req) begin
        set |= 8'h01;
        if (c.ph == 2 && (($countones(8'(c.db)) + c.dbp) % 2 == 0)) set |= 8'h04;
      end
      if (c.bsy || c.sel) begin
        m_idle = 0; m_armed = 1;
      end else begin
        m_idle++;
        if (m_armed && m_idle == FREE) begin set |= 8'h08; m_armed = 0; end
      end
      clr = (wr && addr == 1) ? (int'(wdata) & 8'hAF) : 0;
      if (c.ack) clr |= 1;
      m_st = (m_st & ~clr) | set;
      if (wr && addr == 0) m_exp = int'(wdata) >> 5;
      if (wr && addr == 2) m_en = int'(wdata);
      m_stall = (hist[1].ph != m_exp) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      chk(int'(stall) == m_stall, "R3 stall vs model", int'(stall), m_stall);
      chk(int'(irq) == m_irq, "R10 irq vs model", int'(irq), m_irq);
      chk(int'(rdata) == m_rd, "R2 rdata vs model", int'(rdata), m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk);
    wr = 1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(int a, output int v);
    @(negedge clk);
    rd = 1; addr = 2'(a);
    @(negedge clk);
    rd = 0;
    v = int'(rdata);
  endtask

  task automatic set_ph(int code);
    cd = code[2]; io = code[1]; msg = code[0];
  endtask

  task automatic exp_bits(int v, int mask, int want, string tag);
    chk((v & mask) == want, tag, v & mask, want);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    int v;
    int codes[6] = '{0, 2, 4, 6, 5, 7};
    repeat (4) @(negedge clk);
    rst_n = 1;
    started = 1;

    // R12 reset state
    rd_reg(0, v); chk(v == 0, "R12 expected phase", v, 0);
    rd_reg(1, v); chk(v == 0, "R12 status", v, 0);
    rd_reg(2, v); chk(v == 0, "R12 enables", v, 0);
    chk(stall == 0 && irq == 0, "R12 stall/irq", {stall, irq}, 0);

    // R2 readback and unmapped address
    wr_reg(0, 8'hFF);
    rd_reg(0, v); chk(v == 8'hE0, "R2 phase readback", v, 8'hE0);
    chk(stall == 1, "R3 mismatch raises stall", stall, 1);
    wr_reg(0, 8'h00);
    chk(stall == 0, "R3 matching write releases", stall, 0);
    rd_reg(3, v); chk(v == 0, "R2 unmapped read", v, 0);

    // R11 latency through synchronizer
    @(negedge clk); set_ph(3'b100);
    @(negedge clk); chk(stall == 0, "R11 one edge later", stall, 0);
    @(negedge clk); chk(stall == 1, "R11 two edges later", stall, 1);

    // R4 live mismatch bit cannot be cleared; R5 phase change sticky
    wr_reg(1, 8'h10);
    rd_reg(1, v);
    exp_bits(v, 8'h10, 8'h10, "R4 live mismatch survives clear");
    exp_bits(v, 8'h02, 8'h02, "R5 phase change set");
    wr_reg(1, 8'h02);
    rd_reg(1, v);
    exp_bits(v, 8'h12, 8'h10, "R5 phase change cleared");
    chk(stall == 1, "R3 stall held without write", stall, 1);
    wr_reg(0, 8'h80);
    chk(stall == 0, "R3 release on COMMAND write", stall, 0);

    // R1 phase encodings
    foreach (codes[i]) begin
      set_ph(codes[i]);
      wr_reg(0, codes[i] << 5);
      wait_cyc(3);
      chk(stall == 0, "R1 phase code matches", stall, 0);
      wr_reg(0, (codes[i] ^ 1) << 5);
      chk(stall == 1, "R1 MSG bit position", stall, 1);
      wr_reg(0, codes[i] << 5);
    end

    // R6 / R9 REQ and parity in DATA IN
    set_ph(2); wr_reg(0, 8'h40); wait_cyc(3); wr_reg(1, 8'hFF);
    @(negedge clk); db = 8'h01; dbp = 0; req = 1;
    wait_cyc(4);
    rd_reg(1, v);
    exp_bits(v, 8'h05, 8'h01, "R6 req seen, R9 odd parity ok");
    @(negedge clk); ack = 1;
    wait_cyc(4);
    rd_reg(1, v); exp_bits(v, 8'h01, 0, "R6 ack clears req seen");
    @(negedge clk); req = 0; ack = 0;
    wait_cyc(3);
    @(negedge clk); db = 8'h03; dbp = 0; req = 1;
    wait_cyc(4);
    rd_reg(1, v); exp_bits(v, 8'h05, 8'h05, "R9 even parity flagged");
    @(negedge clk); req = 0;
    wr_reg(1, 8'h05);
    rd_reg(1, v); exp_bits(v, 8'h05, 0, "R7 parity and req W1C");

    // R9 no parity check outside DATA IN
    set_ph(0); wr_reg(0, 0); wait_cyc(3); wr_reg(1, 8'hFF);
    @(negedge clk); db = 0; dbp = 0; req = 1;
    wait_cyc(4);
    rd_reg(1, v); exp_bits(v, 8'h05, 8'h01, "R9 DATA OUT ignores parity");
    @(negedge clk); req = 0;

    // R7 selection timeout and bus reset
    @(negedge clk); seltmo = 1;
    @(negedge clk); seltmo = 0;
    rd_reg(1, v); exp_bits(v, 8'h80, 8'h80, "R7 selection timeout set");
    wr_reg(1, 8'h80);
    rd_reg(1, v); exp_bits(v, 8'h80, 0, "R7 selection timeout cleared");
    @(negedge clk); brst = 1;
    wait_cyc(4);
    rd_reg(1, v); exp_bits(v, 8'h20, 8'h20, "R7 bus reset set");
    wr_reg(1, 8'h20); wait_cyc(2);
    rd_reg(1, v); exp_bits(v, 8'h20, 0, "R7 held reset line edge only");
    @(negedge clk); brst = 0;

    // R8 bus free
    @(negedge clk); bsy = 1;
    wait_cyc(4);
    rd_reg(1, v); exp_bits(v, 8'h08, 0, "R8 not free while busy");
    @(negedge clk); bsy = 0;
    wait_cyc(6);
    rd_reg(1, v); exp_bits(v, 8'h08, 8'h08, "R8 bus free detected");
    wr_reg(1, 8'h08); wait_cyc(6);
    rd_reg(1, v); exp_bits(v, 8'h08, 0, "R8 once per idle period");

    // R10 interrupt masking
    wr_reg(1, 8'hFF);
    wr_reg(2, 8'h80);
    @(negedge clk); seltmo = 1;
    @(negedge clk); seltmo = 0;
    @(negedge clk); chk(irq == 1, "R10 enabled flag raises irq", irq, 1);
    wr_reg(1, 8'h80);
    @(negedge clk); chk(irq == 0, "R10 irq drops after clear", irq, 0);
    @(negedge clk); brst = 1;
    wait_cyc(4);
    chk(irq == 0, "R10 masked flag no irq", irq, 0);
    rd_reg(1, v); exp_bits(v, 8'h60, 8'h20, "R10 bit6 reads zero");
    wr_reg(2, 8'h20); wait_cyc(2);
    chk(irq == 1, "R10 enable raises irq", irq, 1);
    @(negedge clk); brst = 0;
    wr_reg(1, 8'h20); wait_cyc(2);
    chk(irq == 0, "R10 irq cleared", irq, 0);

    wait_cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule